// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block applies the completion rules of a legacy USB host controller to one transfer descriptor at a time. The schedule walker fetches a descriptor and issues the bus transaction. It then presents the descriptor's control word and token word to this block, together with the outcome of that transaction. The outcome is a byte count, a NAK, a stall, babble or no device.

One clock later the block returns three things: the rewritten control word, which the walker writes back to memory; a two-bit mask of interrupts to be raised at the end of the frame; and a return code. The return code tells the walker whether to advance the queue, to skip to the next entry, or to abandon the frame.

The block also flags a USB error when a descriptor's retry budget runs out. It flags a process error when the token carries an unknown packet identifier.

Top module: `td_status_engine`

## Requirements
- R1: A request on `req_valid_i` produces exactly one `rsp_valid_o` pulse on the following clock. After reset every output is zero.
- R2: When the interrupt-on-complete bit (24) is set, `int_mask_o[0]` is set, even for an inactive descriptor. A descriptor whose active bit (23) is clear returns code 1 (skip) with its control word unchanged.
- R3: An active descriptor whose PID (token bits 7:0) is not IN 0x69, OUT 0xE1 or SETUP 0x2D returns code 3 (abort frame). It raises `proc_err_o` and leaves the control word unchanged.
- R4: The maximum length is (token[31:21]+1) mod 2048. OUT and SETUP transfer the maximum; IN transfers `res_len_i` (result kind 0). On success, bits 10:0 become (len-1) mod 2048, active is cleared, and the code is 0.
- R5: An IN transfer whose `res_len_i` exceeds the maximum, or a babble result (kind 3), sets babble (bit 20) and stalled (bit 22). It clears active and returns code 3.
- R6: An IN success with short-packet detect (bit 29) set and len below the maximum sets `int_mask_o[1]` and returns code 1.
- R7: A no-device result (kind 4) sets timeout (bit 18). If the counter in bits 28:27 is nonzero it is decremented, and on reaching zero active is cleared and `usb_err_o` is raised. A zero counter stays zero and leaves active set. The code is 1.
- R8: A NAK result (kind 1) sets bit 19 and returns code 1. For a SETUP token it also follows the timeout path of R7.
- R9: A stall result (kind 2) sets stalled, clears active and returns code 1.
- R10: With isochronous select (bit 25) set, active is cleared for any result other than an unknown PID, including a NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Descriptor and result presented |
| ctrl_i | input | 32 | Fetched control word |
| token_i | input | 32 | Fetched token word |
| res_kind_i | input | 3 | Outcome: 0 data, 1 NAK, 2 stall, 3 babble, 4 no device |
| res_len_i | input | 12 | Byte count returned for IN data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| ctrl_o | output | 32 | Rewritten control word |
| int_mask_o | output | 2 | Bit 0 completion, bit 1 short packet |
| ret_code_o | output | 2 | 0 advance, 1 skip, 3 abort frame |
| usb_err_o | output | 1 | Retry budget exhausted |
| proc_err_o | output | 1 | Unknown PID seen |

## Verification
Data results are tried at an exact length, a short length and zero length, with and without short-packet detect. These cases separate the advance, skip and length-encoding paths. An overlong IN and a maximum field of all ones exercise the modulo wrap of the maximum length and the babble abort.

No-device results are run with counters 3, 1 and 0, which separates decrement, exhaustion and unlimited retry. NAK is applied on both IN and SETUP, and again with isochronous select set. This shows the SETUP timeout fallback and the forced clearing of active.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int CW = 32;
  localparam int LEN_W = 11;
  localparam int B_SPD = 29;
  localparam int B_CNT_HI = 28;
  localparam int B_CNT_LO = 27;
  localparam int B_ISO = 25;
  localparam int B_IOC = 24;
  localparam int B_ACT = 23;
  localparam int B_STL = 22;
  localparam int B_BAB = 20;
  localparam int B_NAK = 19;
  localparam int B_TMO = 18;

  localparam logic [7:0] PID_IN = 8'h69;
  localparam logic [7:0] PID_OUT = 8'hE1;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  typedef enum logic [2:0] {
    RES_DATA = 3'd0, RES_NAK = 3'd1, RES_STALL = 3'd2,
    RES_BABBLE = 3'd3, RES_NODEV = 3'd4
  } res_kind_e;

  typedef enum logic [1:0] {
    RC_OK = 2'd0, RC_SKIP = 2'd1, RC_ABORT = 2'd3
  } ret_code_e;

  typedef enum logic [2:0] {
    OC_DATA, OC_NAK, OC_STALL, OC_BABBLE, OC_TIMEOUT, OC_BADPID
  } outcome_e;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_pkg::*;
(
  input  logic [CW-1:0]    token_i,
  output logic [LEN_W-1:0] max_len_o,
  output logic             pid_in_o,
  output logic             pid_setup_o,
  output logic             pid_ok_o
);
  logic [7:0] pid;
  assign pid         = token_i[7:0];
  // field holds N-1; all ones wraps to zero
  assign max_len_o   = token_i[CW-1 -: LEN_W] + LEN_W'(1);
  assign pid_in_o    = (pid == PID_IN);
  assign pid_setup_o = (pid == PID_SETUP);
  assign pid_ok_o    = pid_in_o || pid_setup_o || (pid == PID_OUT);
endmodule

// File: rtl/td_outcome.sv
module td_outcome
  import td_pkg::*;
#(
  parameter int RES_LEN_W = 12
) (
  input  logic [2:0]           res_kind_i,
  input  logic [RES_LEN_W-1:0] res_len_i,
  input  logic [LEN_W-1:0]     max_len_i,
  input  logic                 pid_in_i,
  input  logic                 pid_ok_i,
  output outcome_e             outcome_o,
  output logic [LEN_W-1:0]     len_o
);
  logic over;
  assign over = pid_in_i && (res_len_i > RES_LEN_W'(max_len_i));

  always_comb begin
    len_o = max_len_i;
    if (pid_in_i && !over) len_o = res_len_i[LEN_W-1:0];
    if (!pid_ok_i) outcome_o = OC_BADPID;
    else begin
      unique case (res_kind_e'(res_kind_i))
        RES_DATA:   outcome_o = over ? OC_BABBLE : OC_DATA;
        RES_NAK:    outcome_o = OC_NAK;
        RES_STALL:  outcome_o = OC_STALL;
        RES_BABBLE: outcome_o = OC_BABBLE;
        default:    outcome_o = OC_TIMEOUT;
      endcase
    end
  end
endmodule

// File: rtl/td_ctrl_update.sv
module td_ctrl_update
  import td_pkg::*;
(
  input  logic [CW-1:0]    ctrl_i,
  input  outcome_e         outcome_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             pid_in_i,
  input  logic             pid_setup_i,
  output logic [CW-1:0]    ctrl_o,
  output logic [1:0]       mask_o,
  output ret_code_e        ret_o,
  output logic             usb_err_o,
  output logic             proc_err_o
);
  logic       do_tmo;
  logic [1:0] cnt;

  always_comb begin
    ctrl_o     = ctrl_i;
    mask_o     = {1'b0, ctrl_i[B_IOC]};
    ret_o      = RC_SKIP;
    usb_err_o  = 1'b0;
    proc_err_o = 1'b0;
    do_tmo     = 1'b0;
    cnt        = ctrl_i[B_CNT_HI:B_CNT_LO];
    if (ctrl_i[B_ACT]) begin
      if (outcome_i == OC_BADPID) begin
        ret_o      = RC_ABORT;
        proc_err_o = 1'b1;
      end else begin
        if (ctrl_i[B_ISO]) ctrl_o[B_ACT] = 1'b0;
        unique case (outcome_i)
          OC_DATA: begin
            ctrl_o[LEN_W-1:0] = len_i - LEN_W'(1);
            ctrl_o[B_ACT]     = 1'b0;
            if (pid_in_i && ctrl_i[B_SPD] && (len_i < max_len_i)) mask_o[1] = 1'b1;
            else ret_o = RC_OK;
          end
          OC_BABBLE: begin
            ctrl_o[B_BAB] = 1'b1;
            ctrl_o[B_STL] = 1'b1;
            ctrl_o[B_ACT] = 1'b0;
            ret_o         = RC_ABORT;
          end
          OC_STALL: begin
            ctrl_o[B_STL] = 1'b1;
            ctrl_o[B_ACT] = 1'b0;
          end
          OC_NAK: begin
            ctrl_o[B_NAK] = 1'b1;
            do_tmo        = pid_setup_i;
          end
          default: do_tmo = 1'b1;
        endcase
        if (do_tmo) begin
          ctrl_o[B_TMO] = 1'b1;
          if (cnt != 2'd0) begin
            cnt = cnt - 2'd1;
            if (cnt == 2'd0) begin
              ctrl_o[B_ACT] = 1'b0;
              usb_err_o     = 1'b1;
            end
          end
          ctrl_o[B_CNT_HI:B_CNT_LO] = cnt;
        end
      end
    end
  end
endmodule

// File: rtl/td_status_engine.sv
module td_status_engine
  import td_pkg::*;
#(
  parameter int RES_LEN_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [31:0]          ctrl_i,
  input  logic [31:0]          token_i,
  input  logic [2:0]           res_kind_i,
  input  logic [RES_LEN_W-1:0] res_len_i,
  output logic                 rsp_valid_o,
  output logic [31:0]          ctrl_o,
  output logic [1:0]           int_mask_o,
  output logic [1:0]           ret_code_o,
  output logic                 usb_err_o,
  output logic                 proc_err_o
);
  logic [LEN_W-1:0] max_len, len;
  logic             pid_in, pid_setup, pid_ok;
  outcome_e         outcome;
  logic [CW-1:0]    ctrl_nx;
  logic [1:0]       mask_nx;
  ret_code_e        ret_nx;
  logic             uerr_nx, perr_nx;

  td_token_decode u_dec (
    .token_i(token_i), .max_len_o(max_len), .pid_in_o(pid_in),
    .pid_setup_o(pid_setup), .pid_ok_o(pid_ok)
  );

  td_outcome #(.RES_LEN_W(RES_LEN_W)) u_oc (
    .res_kind_i(res_kind_i), .res_len_i(res_len_i), .max_len_i(max_len),
    .pid_in_i(pid_in), .pid_ok_i(pid_ok), .outcome_o(outcome), .len_o(len)
  );

  td_ctrl_update u_upd (
    .ctrl_i(ctrl_i), .outcome_i(outcome), .len_i(len), .max_len_i(max_len),
    .pid_in_i(pid_in), .pid_setup_i(pid_setup), .ctrl_o(ctrl_nx),
    .mask_o(mask_nx), .ret_o(ret_nx), .usb_err_o(uerr_nx), .proc_err_o(perr_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      ctrl_o      <= '0;
      int_mask_o  <= '0;
      ret_code_o  <= '0;
      usb_err_o   <= 1'b0;
      proc_err_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      usb_err_o   <= req_valid_i && uerr_nx;
      proc_err_o  <= req_valid_i && perr_nx;
      if (req_valid_i) begin
        ctrl_o     <= ctrl_nx;
        int_mask_o <= mask_nx;
        ret_code_o <= ret_nx;
      end
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !usb_err_o && !proc_err_o);
  // R3
  proc_err_aborts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_err_o |-> ret_code_o == RC_ABORT && ctrl_o == $past(ctrl_i));
  // R7
  usb_err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_err_o |-> !ctrl_o[B_ACT] && ctrl_o[B_TMO] && ctrl_o[B_CNT_HI:B_CNT_LO] == 2'd0);
  // R4
  advance_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && ret_code_o == RC_OK |-> !ctrl_o[B_ACT]);
  // R2
  ioc_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ctrl_i[B_IOC] |=> int_mask_o[0]);
endmodule

// File: tb/sim_td_status_engine.sv
module sim_td_status_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [31:0] ctrl = '0, token = '0;
  logic [2:0] kind = '0;
  logic [11:0] rlen = '0;
  logic rsp_valid, uerr, perr;
  logic [31:0] ctrl_out;
  logic [1:0] mask, ret;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [31:0] ACT = 32'h0080_0000;
  localparam logic [31:0] TK_IN = 32'h00E0_0569;    // max 8
  localparam logic [31:0] TK_OUT = 32'h00E0_05E1;
  localparam logic [31:0] TK_SETUP = 32'h00E0_052D;

  always #10 clk = ~clk;

  td_status_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .ctrl_i(ctrl), .token_i(token),
    .res_kind_i(kind), .res_len_i(rlen), .rsp_valid_o(rsp_valid), .ctrl_o(ctrl_out),
    .int_mask_o(mask), .ret_code_o(ret), .usb_err_o(uerr), .proc_err_o(perr)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] c, logic [31:0] t, logic [2:0] k, logic [11:0] l);
    @(negedge clk);
    ctrl = c; token = t; kind = k; rlen = l; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_rsp(string tag, logic [31:0] c, logic [1:0] m, logic [1:0] r,
                            logic ue, logic pe);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " ctrl"}, ctrl_out, c);
    chk({tag, " mask"}, {30'd0, mask}, {30'd0, m});
    chk({tag, " code"}, {30'd0, ret}, {30'd0, r});
    chk({tag, " usb_err"}, {31'd0, uerr}, {31'd0, ue});
    chk({tag, " proc_err"}, {31'd0, perr}, {31'd0, pe});
  endtask

  task automatic t_reset;
    chk("R1 reset", {rsp_valid, uerr, perr, mask, ret}, '0);
    chk("R1 reset ctrl", ctrl_out, '0);
  endtask

  task automatic t_strobe;
    run(ACT, TK_OUT, 3'd0, 12'd0);
    chk("R1 strobe", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R1 strobe drop", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_inactive;
    run(32'h0100_0000, TK_IN, 3'd0, 12'd3);
    expect_rsp("R2 inactive ioc", 32'h0100_0000, 2'b01, 2'd1, 0, 0);
  endtask

  task automatic t_badpid;
    run(32'h0180_0000, 32'h00E0_05A5, 3'd0, 12'd0);
    expect_rsp("R3 bad pid", 32'h0180_0000, 2'b01, 2'd3, 0, 1);
  endtask

  task automatic t_success;
    run(ACT | 32'h7FF, TK_OUT, 3'd0, 12'd2);
    expect_rsp("R4 out", 32'h0000_0007, 2'b00, 2'd0, 0, 0);
    run(32'h2080_0000, TK_IN, 3'd0, 12'd8);
    expect_rsp("R4 in exact", 32'h2000_0007, 2'b00, 2'd0, 0, 0);
    run(ACT, TK_IN, 3'd0, 12'd0);
    expect_rsp("R4 in zero", 32'h0000_07FF, 2'b00, 2'd0, 0, 0);
    run(ACT, 32'hFFE0_00E1, 3'd0, 12'd0);
    expect_rsp("R4 max wrap", 32'h0000_07FF, 2'b00, 2'd0, 0, 0);
  endtask

  task automatic t_short;
    run(32'h2080_0000, TK_IN, 3'd0, 12'd3);
    expect_rsp("R6 short spd", 32'h2000_0002, 2'b10, 2'd1, 0, 0);
    run(ACT, TK_IN, 3'd0, 12'd3);
    expect_rsp("R6 short nospd", 32'h0000_0002, 2'b00, 2'd0, 0, 0);
  endtask

  task automatic t_babble;
    run(ACT, TK_IN, 3'd0, 12'd9);
    expect_rsp("R5 overlong", 32'h0050_0000, 2'b00, 2'd3, 0, 0);
    run(ACT, TK_OUT, 3'd3, 12'd0);
    expect_rsp("R5 dev babble", 32'h0050_0000, 2'b00, 2'd3, 0, 0);
  endtask

  task automatic t_timeout;
    run(32'h1880_0000, TK_IN, 3'd4, 12'd0);
    expect_rsp("R7 cnt3", 32'h1084_0000, 2'b00, 2'd1, 0, 0);
    run(32'h0880_0000, TK_IN, 3'd4, 12'd0);
    expect_rsp("R7 cnt1", 32'h0004_0000, 2'b00, 2'd1, 1, 0);
    run(ACT, TK_IN, 3'd4, 12'd0);
    expect_rsp("R7 cnt0", 32'h0084_0000, 2'b00, 2'd1, 0, 0);
  endtask

  task automatic t_nak;
    run(32'h1880_0000, TK_IN, 3'd1, 12'd0);
    expect_rsp("R8 nak in", 32'h1888_0000, 2'b00, 2'd1, 0, 0);
    run(32'h1880_0000, TK_SETUP, 3'd1, 12'd0);
    expect_rsp("R8 nak setup", 32'h108C_0000, 2'b00, 2'd1, 0, 0);
  endtask

  task automatic t_stall;
    run(ACT, TK_IN, 3'd2, 12'd0);
    expect_rsp("R9 stall", 32'h0040_0000, 2'b00, 2'd1, 0, 0);
  endtask

  task automatic t_iso;
    run(32'h0280_0000, TK_IN, 3'd1, 12'd0);
    expect_rsp("R10 iso nak", 32'h0208_0000, 2'b00, 2'd1, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #15;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_strobe();
    t_inactive();
    t_badpid();
    t_success();
    t_short();
    t_babble();
    t_timeout();
    t_nak();
    t_stall();
    t_iso();
    finish_run();
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule